// File: doc/BRIEF.md
# DMA Control and Status Register File

This block is the register file a host uses to run full-duplex DMA between an endpoint and host memory. It decodes single-dword memory reads and writes that fall in its own address window. A separate window-hit input tells it which requests are meant for it. Registers hold the host and local addresses for each direction and a transfer-length code. A command register drives one-cycle start and stop strobes to the transmit-side engine, which handles endpoint-to-host writes, and to the receive-side engine, which handles host-to-endpoint reads.

Completion events from the engines raise sticky done flags, which the host reads and clears. Every read is answered after a fixed number of cycles, so the completion that carries the data never needs to stall. The transfer length cannot be written as a free value: the host picks one of six sizes through a 3-bit code, and the block drives the decoded dword count to the engines.

Top module: `dma_csr_top`

## Requirements
- R1: After reset, every register reads 0, no strobe is active and `xfer_len_o` is 1024.
- R2: The address registers sit at dword offsets 2 (host source), 3 (host destination), 4 (local source) and 5 (local destination). Each reads back what was last written, limited to `HADDR_W` bits for host addresses and `LADDR_W` bits for local addresses. Bits above that width read 0.
- R3: Offset 6 holds a length code in bits [2:0]. Codes 0 to 5 give 1024, 2048, 3072, 4096, 8192 and 16384 dwords on `xfer_len_o`. Writing code 6 or 7 stores 0, so it reads back 0 and the length becomes 1024.
- R4: Writing the command register (offset 0) with bit 0 set produces a one-cycle `wr_start_o` in the cycle after the write. Bit 1 does the same for `rd_start_o`. The command register always reads 0, and no start strobe occurs without such a write.
- R5: The two directions are independent. Setting bits 0 and 1 in one write starts both engines in the same cycle.
- R6: Status bits 2 (write busy) and 3 (read busy) are set by a start. A start request for a busy direction is ignored.
- R7: Command bits 2 (stop write) and 3 (stop read) give a one-cycle stop strobe and clear busy, but only when that direction is busy. A stop for an idle direction gives no strobe. A stop bit beats the start bit of the same direction in the same write.
- R8: `wr_done_i` and `rd_done_i` set sticky status bits 0 and 1 and clear the matching busy bit. Writing 1 to a status done bit clears it. A done event in the same cycle as that clear leaves the bit set.
- R9: Requests with `req_win_hit_i` low are ignored and get no response. Offsets above 6 read 0 and ignore writes.
- R10: A read accepted in cycle c raises `rsp_valid_o` for exactly one cycle, in cycle c+`RD_LAT`, and never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Single-dword request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_win_hit_i | input | 1 | Request falls in this block's address window |
| req_ofs_i | input | OFS_W | Dword offset within the window |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_data_o | output | DATA_W | Read data |
| wr_done_i | input | 1 | Write-direction engine finished |
| rd_done_i | input | 1 | Read-direction engine finished |
| wr_start_o | output | 1 | Start strobe, write direction |
| wr_stop_o | output | 1 | Stop strobe, write direction |
| rd_start_o | output | 1 | Start strobe, read direction |
| rd_stop_o | output | 1 | Stop strobe, read direction |
| host_src_o | output | HADDR_W | Host source address |
| host_dst_o | output | HADDR_W | Host destination address |
| loc_src_o | output | LADDR_W | Local source address |
| loc_dst_o | output | LADDR_W | Local destination address |
| xfer_len_o | output | LEN_W | Transfer length in dwords |

## Verification
The assertions check the following on every cycle:
- each start strobe follows a command write carrying its bit, into an idle direction;
- stop strobes only come from a busy state;
- a done event always leaves its flag set;
- no response appears without an outstanding read;
- the length output is always one of the six legal sizes.

The bench scenarios cover what a single-cycle property cannot see: register readback widths, the mapping of each length code, the full busy/done/clear sequence across both directions, precedence when events and writes collide, window misses, and the exact response cycle.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

   // Register offsets inside the window (field positions decoded by the engines' driver)
   localparam int REG_CTRL = 0;
   localparam int REG_STAT = 1;
   localparam int REG_HSRC = 2;
   localparam int REG_LEN  = 6;
   localparam int NUM_REGS = 7;
   localparam int NUM_ADDR = 4;

   // Direction indices
   localparam int DIR_WR  = 0;
   localparam int DIR_RD  = 1;
   localparam int NUM_DIR = 2;

   localparam int LEN_CODE_W = 3;

   // Reserved codes collapse to 0
   function automatic logic [LEN_CODE_W-1:0] len_code_clean(input logic [LEN_CODE_W-1:0] c);
      return (c > 3'd5) ? '0 : c;
   endfunction

   // Code to dword count
   function automatic int unsigned len_code_dw(input logic [LEN_CODE_W-1:0] c);
      int unsigned n;
      case (c)
         3'd0:    n = 1024;
         3'd1:    n = 2048;
         3'd2:    n = 3072;
         3'd3:    n = 4096;
         3'd4:    n = 8192;
         3'd5:    n = 16384;
         default: n = 1024;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode #(
   parameter int OFS_W    = 4,
   parameter int NUM_REGS = 7
) (
   input  logic                req_valid_i,
   input  logic                req_write_i,
   input  logic                req_win_hit_i,
   input  logic [OFS_W-1:0]    req_ofs_i,
   output logic [NUM_REGS-1:0] wr_sel_o,
   output logic [NUM_REGS-1:0] rd_sel_o,
   output logic                rd_req_o
);

   logic acc;
   assign acc      = req_valid_i & req_win_hit_i;
   assign rd_req_o = acc & ~req_write_i;

   // One select line per implemented register; unmapped offsets hit none
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
      logic hit;
      assign hit         = (req_ofs_i == OFS_W'(g));
      assign wr_sel_o[g] = acc &  req_write_i & hit;
      assign rd_sel_o[g] = acc & ~req_write_i & hit;
   end

endmodule

// File: rtl/dma_csr_dir.sv
module dma_csr_dir (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ctrl_wr_i,
   input  logic start_bit_i,
   input  logic stop_bit_i,
   input  logic sts_wr_i,
   input  logic clr_bit_i,
   input  logic done_evt_i,
   output logic start_o,
   output logic stop_o,
   output logic busy_o,
   output logic done_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         start_o <= 1'b0;
         stop_o  <= 1'b0;
         busy_o  <= 1'b0;
         done_o  <= 1'b0;
      end else begin
         start_o <= 1'b0;
         stop_o  <= 1'b0;
         if (done_evt_i) busy_o <= 1'b0;
         if (ctrl_wr_i) begin
            if (stop_bit_i) begin
               if (busy_o) begin
                  stop_o <= 1'b1;
                  busy_o <= 1'b0;
               end
            end else if (start_bit_i && !busy_o) begin
               start_o <= 1'b1;
               busy_o  <= 1'b1;
            end
         end
         // write-one-to-clear, event wins
         if (sts_wr_i && clr_bit_i) done_o <= 1'b0;
         if (done_evt_i)            done_o <= 1'b1;
      end
   end

endmodule

// File: rtl/dma_csr_addr_reg.sv
module dma_csr_addr_reg #(
   parameter int DATA_W = 32,
   parameter int REG_W  = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [REG_W-1:0]  wdata_i,
   output logic [REG_W-1:0]  q_o,
   output logic [DATA_W-1:0] view_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o <= '0;
      else if (we_i) q_o <= wdata_i;
   end

   assign view_o = DATA_W'(q_o);

endmodule

// File: rtl/dma_csr_rdpipe.sv
module dma_csr_rdpipe #(
   parameter int DATA_W = 32,
   parameter int LAT    = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o
);

   logic [LAT-1:0]    v_q;
   logic [DATA_W-1:0] d_q [LAT];

   if (LAT == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            v_q    <= '0;
            d_q[0] <= '0;
         end else begin
            v_q[0] <= req_i;
            d_q[0] <= data_i;
         end
      end
   end else begin : g_shift
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            v_q <= '0;
            for (int i = 0; i < LAT; i++) d_q[i] <= '0;
         end else begin
            v_q    <= {v_q[LAT-2:0], req_i};
            d_q[0] <= data_i;
            for (int i = 1; i < LAT; i++) d_q[i] <= d_q[i-1];
         end
      end
   end

   assign valid_o = v_q[LAT-1];
   assign data_o  = v_q[LAT-1] ? d_q[LAT-1] : '0;

endmodule

// File: rtl/dma_csr_top.sv
module dma_csr_top
   import dma_csr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int OFS_W   = 4,
   parameter int HADDR_W = 32,
   parameter int LADDR_W = 16,
   parameter int LEN_W   = 15,
   parameter int RD_LAT  = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               req_valid_i,
   input  logic               req_write_i,
   input  logic               req_win_hit_i,
   input  logic [OFS_W-1:0]   req_ofs_i,
   input  logic [DATA_W-1:0]  req_wdata_i,
   output logic               rsp_valid_o,
   output logic [DATA_W-1:0]  rsp_data_o,
   input  logic               wr_done_i,
   input  logic               rd_done_i,
   output logic               wr_start_o,
   output logic               wr_stop_o,
   output logic               rd_start_o,
   output logic               rd_stop_o,
   output logic [HADDR_W-1:0] host_src_o,
   output logic [HADDR_W-1:0] host_dst_o,
   output logic [LADDR_W-1:0] loc_src_o,
   output logic [LADDR_W-1:0] loc_dst_o,
   output logic [LEN_W-1:0]   xfer_len_o
);

   // Elaboration-time parameter checks
   if (DATA_W < 16)                     begin : g_bad_dw  $error("DATA_W too small"); end
   if (OFS_W < 3)                       begin : g_bad_ofs $error("OFS_W cannot reach all registers"); end
   if (HADDR_W > DATA_W || HADDR_W < 1) begin : g_bad_ha  $error("HADDR_W out of range"); end
   if (LADDR_W > DATA_W || LADDR_W < 1) begin : g_bad_la  $error("LADDR_W out of range"); end
   if (LEN_W < 15)                      begin : g_bad_len $error("LEN_W cannot hold 16K"); end
   if (RD_LAT < 1 || RD_LAT > 8)        begin : g_bad_lat $error("RD_LAT out of range"); end

   localparam int AMAX_W = (HADDR_W > LADDR_W) ? HADDR_W : LADDR_W;

   logic [NUM_REGS-1:0] wr_sel, rd_sel;
   logic                rd_req;

   dma_csr_decode #(.OFS_W(OFS_W), .NUM_REGS(NUM_REGS)) u_dec (
      .req_valid_i   (req_valid_i),
      .req_write_i   (req_write_i),
      .req_win_hit_i (req_win_hit_i),
      .req_ofs_i     (req_ofs_i),
      .wr_sel_o      (wr_sel),
      .rd_sel_o      (rd_sel),
      .rd_req_o      (rd_req)
   );

   // Per-direction command/status slices: start bit d, stop bit d+2, done bit d, busy bit d+2
   logic [NUM_DIR-1:0] start_vec, stop_vec, sts_busy, sts_done, done_vec;
   assign done_vec[DIR_WR] = wr_done_i;
   assign done_vec[DIR_RD] = rd_done_i;

   for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
      dma_csr_dir u_dir (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .ctrl_wr_i   (wr_sel[REG_CTRL]),
         .start_bit_i (req_wdata_i[d]),
         .stop_bit_i  (req_wdata_i[d+NUM_DIR]),
         .sts_wr_i    (wr_sel[REG_STAT]),
         .clr_bit_i   (req_wdata_i[d]),
         .done_evt_i  (done_vec[d]),
         .start_o     (start_vec[d]),
         .stop_o      (stop_vec[d]),
         .busy_o      (sts_busy[d]),
         .done_o      (sts_done[d])
      );
   end

   assign wr_start_o = start_vec[DIR_WR];
   assign wr_stop_o  = stop_vec[DIR_WR];
   assign rd_start_o = start_vec[DIR_RD];
   assign rd_stop_o  = stop_vec[DIR_RD];

   // Address registers: first two host-wide, last two local-wide
   logic [DATA_W-1:0] addr_view [NUM_ADDR];
   logic [AMAX_W-1:0] addr_q    [NUM_ADDR];

   for (genvar k = 0; k < NUM_ADDR; k++) begin : g_addr
      localparam int AW = (k < 2) ? HADDR_W : LADDR_W;
      logic [AW-1:0] q;
      dma_csr_addr_reg #(.DATA_W(DATA_W), .REG_W(AW)) u_reg (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .we_i    (wr_sel[REG_HSRC+k]),
         .wdata_i (req_wdata_i[AW-1:0]),
         .q_o     (q),
         .view_o  (addr_view[k])
      );
      assign addr_q[k] = AMAX_W'(q);
   end

   assign host_src_o = addr_q[0][HADDR_W-1:0];
   assign host_dst_o = addr_q[1][HADDR_W-1:0];
   assign loc_src_o  = addr_q[2][LADDR_W-1:0];
   assign loc_dst_o  = addr_q[3][LADDR_W-1:0];

   // Length code
   logic [LEN_CODE_W-1:0] len_code_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              len_code_q <= '0;
      else if (wr_sel[REG_LEN]) len_code_q <= len_code_clean(req_wdata_i[LEN_CODE_W-1:0]);
   end
   assign xfer_len_o = LEN_W'(len_code_dw(len_code_q));

   // Read mux
   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (rd_sel[REG_STAT]) rd_mux = DATA_W'({sts_busy, sts_done});
      for (int k = 0; k < NUM_ADDR; k++)
         if (rd_sel[REG_HSRC+k]) rd_mux = addr_view[k];
      if (rd_sel[REG_LEN]) rd_mux = DATA_W'(len_code_q);
   end

   dma_csr_rdpipe #(.DATA_W(DATA_W), .LAT(RD_LAT)) u_rsp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (rd_req),
      .data_i  (rd_mux),
      .valid_o (rsp_valid_o),
      .data_o  (rsp_data_o)
   );

endmodule

// File: rtl/dma_csr_chk.sv
module dma_csr_chk #(
   parameter int OFS_W = 4,
   parameter int LEN_W = 15
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             req_valid_i,
   input logic             req_write_i,
   input logic             req_win_hit_i,
   input logic [OFS_W-1:0] req_ofs_i,
   input logic [1:0]       start_bits,
   input logic             wr_done_i,
   input logic             rd_done_i,
   input logic             wr_start_o,
   input logic             rd_start_o,
   input logic             wr_stop_o,
   input logic             rd_stop_o,
   input logic             rsp_valid_o,
   input logic [LEN_W-1:0] xfer_len_o,
   input logic [1:0]       sts_busy,
   input logic [1:0]       sts_done
);

   logic ctrl_wr, rd_acc;
   assign ctrl_wr = req_valid_i & req_write_i & req_win_hit_i & (req_ofs_i == '0);
   assign rd_acc  = req_valid_i & ~req_write_i & req_win_hit_i;

   logic [3:0] outst;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) outst <= '0;
      else         outst <= outst + 4'(rd_acc) - 4'(rsp_valid_o);
   end

   // R4
   wr_start_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_start_o |-> $past(ctrl_wr && start_bits[0]));
   // R4
   rd_start_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_start_o |-> $past(ctrl_wr && start_bits[1]));
   // R6
   wr_start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_start_o |-> !$past(sts_busy[0]));
   // R6
   rd_start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_start_o |-> !$past(sts_busy[1]));
   // R7
   wr_stop_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_stop_o |-> $past(sts_busy[0]));
   // R7
   rd_stop_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_stop_o |-> $past(sts_busy[1]));
   // R8
   wr_done_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_done_i |=> sts_done[0]);
   // R8
   rd_done_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_done_i |=> sts_done[1]);
   // R10
   rsp_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o |-> (outst != 4'd0));
   // R3
   len_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($countones(xfer_len_o) == 1 && xfer_len_o >= LEN_W'(1024) && xfer_len_o <= LEN_W'(16384))
      || xfer_len_o == LEN_W'(3072));

endmodule

bind dma_csr_top dma_csr_chk #(.OFS_W(OFS_W), .LEN_W(LEN_W)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .req_valid_i   (req_valid_i),
   .req_write_i   (req_write_i),
   .req_win_hit_i (req_win_hit_i),
   .req_ofs_i     (req_ofs_i),
   .start_bits    (req_wdata_i[1:0]),
   .wr_done_i     (wr_done_i),
   .rd_done_i     (rd_done_i),
   .wr_start_o    (wr_start_o),
   .rd_start_o    (rd_start_o),
   .wr_stop_o     (wr_stop_o),
   .rd_stop_o     (rd_stop_o),
   .rsp_valid_o   (rsp_valid_o),
   .xfer_len_o    (xfer_len_o),
   .sts_busy      (sts_busy),
   .sts_done      (sts_done)
);

// File: tb/dma_csr_top_tb_top.sv
`timescale 1ns/1ps
module dma_csr_top_tb_top;

   localparam int RD_LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 0, req_write = 0, req_hit = 0;
   logic [3:0]  req_ofs = '0;
   logic [31:0] req_wdata = '0;
   logic        wr_done = 0, rd_done = 0;
   logic        rsp_valid, wr_start, wr_stop, rd_start, rd_stop;
   logic [31:0] rsp_data, host_src, host_dst;
   logic [15:0] loc_src, loc_dst;
   logic [14:0] xfer_len;

   always #2 clk = ~clk;

   dma_csr_top #(.RD_LAT(RD_LAT)) dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .req_valid_i(req_valid), .req_write_i(req_write), .req_win_hit_i(req_hit),
      .req_ofs_i(req_ofs), .req_wdata_i(req_wdata),
      .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
      .wr_done_i(wr_done), .rd_done_i(rd_done),
      .wr_start_o(wr_start), .wr_stop_o(wr_stop), .rd_start_o(rd_start), .rd_stop_o(rd_stop),
      .host_src_o(host_src), .host_dst_o(host_dst), .loc_src_o(loc_src), .loc_dst_o(loc_dst),
      .xfer_len_o(xfer_len)
   );

   int  total = 0, bad = 0;
   bit  finished = 0;
   logic [3:0] snap;   // {rd_stop, wr_stop, rd_start, wr_start} after a write

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [3:0] ofs, input logic [31:0] d, input logic hit = 1'b1);
      @(negedge clk);
      req_valid = 1; req_write = 1; req_ofs = ofs; req_wdata = d; req_hit = hit;
      @(negedge clk);
      req_valid = 0; req_write = 0;
      snap = {rd_stop, wr_stop, rd_start, wr_start};
   endtask

   task automatic do_rd(input logic [3:0] ofs, output logic [31:0] d, output logic lat_ok);
      @(negedge clk);
      req_valid = 1; req_write = 0; req_ofs = ofs; req_hit = 1;
      @(negedge clk);
      req_valid = 0;
      lat_ok = 1;
      for (int i = 1; i < RD_LAT; i++) begin
         if (rsp_valid) lat_ok = 0;
         @(negedge clk);
      end
      if (!rsp_valid) lat_ok = 0;
      d = rsp_data;
      @(negedge clk);
      if (rsp_valid) lat_ok = 0;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] ofs, input logic [31:0] exp);
      logic [31:0] d;
      logic ok;
      do_rd(ofs, d, ok);
      chk("R10 latency", 32'(ok), 32'd1);
      chk(req, d, exp);
   endtask

   function automatic logic [14:0] exp_len(input int code);
      case (code)
         1: return 15'd2048;  2: return 15'd3072;  3: return 15'd4096;
         4: return 15'd8192;  5: return 15'd16384; default: return 15'd1024;
      endcase
   endfunction

   // {op(0=write,1=read), ofs, data, expected}
   localparam int NV = 17;
   localparam logic [69:0] VEC [NV] = '{
      {2'd0, 4'd2, 32'h1234_5678, 32'h0},
      {2'd1, 4'd2, 32'h0,         32'h1234_5678},
      {2'd0, 4'd3, 32'hFFFF_0000, 32'h0},
      {2'd1, 4'd3, 32'h0,         32'hFFFF_0000},
      {2'd0, 4'd4, 32'hDEAD_BEEF, 32'h0},
      {2'd1, 4'd4, 32'h0,         32'h0000_BEEF},
      {2'd0, 4'd5, 32'h0001_A5A5, 32'h0},
      {2'd1, 4'd5, 32'h0,         32'h0000_A5A5},
      {2'd0, 4'd6, 32'h0000_0003, 32'h0},
      {2'd1, 4'd6, 32'h0,         32'h0000_0003},
      {2'd0, 4'd6, 32'h0000_0007, 32'h0},
      {2'd1, 4'd6, 32'h0,         32'h0000_0000},
      {2'd0, 4'd6, 32'hFFFF_FFFD, 32'h0},
      {2'd1, 4'd6, 32'h0,         32'h0000_0005},
      {2'd0, 4'd7, 32'hFFFF_FFFF, 32'h0},
      {2'd1, 4'd7, 32'h0,         32'h0},
      {2'd1, 4'd2, 32'h0,         32'h1234_5678}
   };

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 strobes", 32'({rd_stop, wr_stop, rd_start, wr_start, rsp_valid}), 32'd0);
      chk("R1 len", 32'(xfer_len), 32'd1024);
      for (int o = 0; o < 7; o++) rd_chk("R1 reg", 4'(o), 32'h0);

      // Table walk: R2 addresses, R3 length codes, R9 unmapped offset
      for (int v = 0; v < NV; v++) begin
         logic [3:0] o;
         o = VEC[v][67:64];
         if (VEC[v][69:68] == 2'd0) do_wr(o, VEC[v][63:32]);
         else rd_chk(o == 4'd6 ? "R3 code" : (o == 4'd7 ? "R9 unmapped" : "R2 addr"), o, VEC[v][31:0]);
      end
      chk("R2 host_src out", host_src, 32'h1234_5678);
      chk("R2 loc_src out", 32'(loc_src), 32'h0000_BEEF);

      // R3 every code on the length output
      for (int c = 0; c < 8; c++) begin
         do_wr(4'd6, 32'(c));
         chk("R3 len", 32'(xfer_len), 32'(exp_len(c)));
      end

      // R4 write start
      do_wr(4'd0, 32'h1);
      chk("R4 wr_start pulse", 32'(snap), 32'h1);
      @(negedge clk);
      chk("R4 one cycle", 32'(wr_start), 32'h0);
      rd_chk("R4 ctrl reads 0", 4'd0, 32'h0);
      rd_chk("R6 wr busy", 4'd1, 32'h4);
      // R6 start while busy ignored
      do_wr(4'd0, 32'h1);
      chk("R6 ignored start", 32'(snap), 32'h0);
      // R7 stop while busy
      do_wr(4'd0, 32'h4);
      chk("R7 wr_stop pulse", 32'(snap), 32'h4);
      rd_chk("R7 busy cleared", 4'd1, 32'h0);
      do_wr(4'd0, 32'h4);
      chk("R7 idle stop", 32'(snap), 32'h0);
      // R5 both directions at once
      do_wr(4'd0, 32'h3);
      chk("R5 both start", 32'(snap), 32'h3);
      rd_chk("R5 both busy", 4'd1, 32'hC);

      // R8 done events
      @(negedge clk); wr_done = 1; @(negedge clk); wr_done = 0;
      chk("R8 no strobe on done", 32'(wr_start), 32'h0);
      rd_chk("R8 wr done", 4'd1, 32'h9);
      @(negedge clk); rd_done = 1; @(negedge clk); rd_done = 0;
      rd_chk("R8 rd done", 4'd1, 32'h3);
      do_wr(4'd1, 32'h1);
      rd_chk("R8 w1c", 4'd1, 32'h2);
      @(negedge clk);
      req_valid = 1; req_write = 1; req_ofs = 4'd1; req_wdata = 32'h2; req_hit = 1; rd_done = 1;
      @(negedge clk);
      req_valid = 0; req_write = 0; rd_done = 0;
      rd_chk("R8 set wins", 4'd1, 32'h2);
      do_wr(4'd1, 32'h2);
      rd_chk("R8 cleared", 4'd1, 32'h0);

      // R7 stop beats start when idle
      do_wr(4'd0, 32'h5);
      chk("R7 stop wins", 32'(snap), 32'h0);
      rd_chk("R7 still idle", 4'd1, 32'h0);

      // R9 window miss
      do_wr(4'd2, 32'hAAAA_AAAA, 1'b0);
      do_wr(4'd0, 32'h3, 1'b0);
      chk("R9 miss no start", 32'(snap), 32'h0);
      rd_chk("R9 miss no write", 4'd2, 32'h1234_5678);
      @(negedge clk);
      req_valid = 1; req_write = 0; req_ofs = 4'd2; req_hit = 0;
      @(negedge clk);
      req_valid = 0;
      begin
         logic seen;
         seen = 0;
         for (int i = 0; i < RD_LAT + 2; i++) begin
            if (rsp_valid) seen = 1;
            @(negedge clk);
         end
         chk("R9 miss no response", 32'(seen), 32'h0);
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule